// File: doc/BRIEF.md
# Transport Stream Capture Writer

This block takes a byte-wide MPEG transport stream, with a byte strobe and a packet-start marker, and stores it in a circular buffer in system memory. The bytes are packed into 32-bit words. Each word leaves on a simple valid/ready write port that carries an address and a data word. Only packets that open with the sync byte 0x47 are kept. Stored data therefore stays aligned to whole packets, with packet n at base + n·(packet length), wrapping at the end of the ring.

Software programs the ring base, the ring length, the packet length and the number of packets per interrupt through a small word-indexed register port. It reads back the absolute address of the next memory write, so the fill level is that address minus the base. A packet-count interrupt and a sticky overflow flag share a status register with a mask and a global enable. Writing a 1 to the restart register resumes capture at the ring base, which is how loss of sync or an overflow is recovered.

Register indices on `cfg_addr`: 0 control (bit 0 interrupt enable), 1 ring base, 2 ring length in bytes, 3 packet length in bytes, 4 packets per interrupt, 5 write pointer (read only), 6 interrupt mask, 7 status, 8 restart (write only, reads 0).

Top module: `ts_capture_dma`

## Requirements
- R1: After reset, `mem_valid` and `irq` are 0, control reads 0, the packet length reads 188, packets-per-interrupt reads 47 and the write pointer reads 0. A register read returns its value on `cfg_rdata` one clock after `cfg_addr` is presented.
- R2: A packet is accepted only when a byte with `ts_sop` high equals 0x47. Any other byte seen while no packet is open is discarded. Inside an accepted packet every valid byte is taken until the packet length is reached, and `ts_sop` has no effect there.
- R3: The bytes are packed little-endian: the first byte goes to bits 7:0 and the fourth to bits 31:24. A word is issued only once all four of its bytes have arrived. Words go to consecutive, 4-byte aligned addresses starting at the ring base. The packet length and the ring length must be multiples of 4.
- R4: When the next address would reach base + ring length, the address returns to the ring base.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold their values.
- R6: The write pointer (index 5) reads the absolute address that follows the last accepted memory write, wrapped as in R4.
- R7: Status bit 0 is set once the packets-per-interrupt count of packets has had its final word accepted on the memory port. The count then starts again from zero.
- R8: `irq` is a register. It equals control bit 0 AND the OR of (status AND mask) as they stood one clock earlier.
- R9: Writing to status (index 7) clears each bit written as 1. A bit being set in the same clock wins over the clear.
- R10: If a word completes while the word queue is full, status bit 1 is set and stays set. The rest of that packet is dropped, and the next accepted packet is written at the dropped packet's start address.
- R11: Writing 1 to bit 0 of the restart register (index 8) does all of the following at once: it empties the word queue, discards any partial packet, clears the packet count, and returns both the write address and the write pointer to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_data | input | 8 | Stream byte |
| ts_valid | input | 1 | Byte strobe |
| ts_sop | input | 1 | Marks the first byte of a packet |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Absolute byte address of the word |
| mem_data | output | 32 | Packed data word |
| irq | output | 1 | Interrupt request |

## Verification
The stream is tried with several patterns. Clean back-to-back packets show the packing order, the address sequence and the wrap. A wrong sync byte, stray bytes and a start marker inside a packet separate sync hunting from byte counting. A stalled memory port, first short and then long enough to fill the queue, shows holding apart from overflow-and-rewind. A restart issued mid-packet and a switch to full 188-byte packets with one packet per interrupt show recovery and the interrupt count. A behavioural model built on queues follows every clock, and it exposes any slip in address, data or interrupt timing.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [3:0] {
    IDX_CTRL  = 4'd0,
    IDX_BASE  = 4'd1,
    IDX_RING  = 4'd2,
    IDX_PLEN  = 4'd3,
    IDX_PIRQ  = 4'd4,
    IDX_WPTR  = 4'd5,
    IDX_MASK  = 4'd6,
    IDX_STAT  = 4'd7,
    IDX_RSTRT = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic              last;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_entry_t;

  // Next word address inside the ring, folding back to the base at the end
  function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] addr,
                                                 input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] len);
    logic [ADDR_W-1:0] off;
    off = addr - base + 32'd4;
    return (off >= len) ? base : addr + 32'd4;
  endfunction
endpackage

// File: rtl/ts_cap_fifo.sv
module ts_cap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 65
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (PW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ts_cap_ingest.sv
module ts_cap_ingest
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [7:0]        ts_data,
  input  logic              ts_valid,
  input  logic              ts_sop,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] ring_len,
  input  logic              q_full,
  output logic              push,
  output wr_entry_t         push_entry,
  output logic              ovf_pulse
);
  logic              in_pkt_q;
  logic [LEN_W-1:0]  bcnt_q, bcnt_nx;
  logic [1:0]        lane_q;
  logic [7:0]        b0_q, b1_q, b2_q;
  logic [ADDR_W-1:0] waddr_q, pbase_q, waddr_nx;
  logic              take_first, take, word_done, last;

  always_comb begin
    take_first = ts_valid && !in_pkt_q && ts_sop && (ts_data == SYNC_BYTE);
    take       = ts_valid && in_pkt_q;
    word_done  = take && (lane_q == 2'd3);
    bcnt_nx    = bcnt_q + 1'b1;
    last       = (bcnt_nx == pkt_len);
    push       = word_done && !q_full;
    ovf_pulse  = word_done && q_full;
    waddr_nx   = ring_step(waddr_q, base, ring_len);
    push_entry.last = last;
    push_entry.addr = waddr_q;
    push_entry.data = {ts_data, b2_q, b1_q, b0_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      bcnt_q   <= '0;
      lane_q   <= '0;
      b0_q     <= '0;
      b1_q     <= '0;
      b2_q     <= '0;
      waddr_q  <= '0;
      pbase_q  <= '0;
    end else if (restart) begin
      in_pkt_q <= 1'b0;
      lane_q   <= '0;
      waddr_q  <= base;
      pbase_q  <= base;
    end else if (take_first) begin
      in_pkt_q <= 1'b1;
      bcnt_q   <= LEN_W'(1);
      lane_q   <= 2'd1;
      b0_q     <= ts_data;
    end else if (take) begin
      if (ovf_pulse) begin
        in_pkt_q <= 1'b0;
        lane_q   <= '0;
        waddr_q  <= pbase_q;
      end else begin
        bcnt_q <= bcnt_nx;
        lane_q <= lane_q + 1'b1;
        case (lane_q)
          2'd0:    b0_q <= ts_data;
          2'd1:    b1_q <= ts_data;
          2'd2:    b2_q <= ts_data;
          default: ;
        endcase
        if (word_done) begin
          waddr_q <= waddr_nx;
          if (last) pbase_q <= waddr_nx;
        end
        if (last) in_pkt_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ts_cap_regs.sv
module ts_cap_regs
  import ts_cap_pkg::*;
#(
  parameter int unsigned RING_RST = 3760,
  parameter int unsigned PLEN_RST = 188,
  parameter int unsigned PIRQ_RST = 47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              hs,
  input  logic [ADDR_W-1:0] hs_addr,
  input  logic              hs_last,
  input  logic              ovf_pulse,
  output logic              restart,
  output logic              irq_en,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] ring_len,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [1:0]        stat,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              irq
);
  logic [LEN_W-1:0] pkts_per_irq, pcnt_q;
  logic [1:0]       mask_q, clr, set;
  logic             wr_ctrl, wr_base, wr_ring, wr_plen, wr_pirq, wr_mask, wr_stat;
  logic             pkt_done, hit;

  always_comb begin
    wr_ctrl  = cfg_wr && (cfg_addr == IDX_CTRL);
    wr_base  = cfg_wr && (cfg_addr == IDX_BASE);
    wr_ring  = cfg_wr && (cfg_addr == IDX_RING);
    wr_plen  = cfg_wr && (cfg_addr == IDX_PLEN);
    wr_pirq  = cfg_wr && (cfg_addr == IDX_PIRQ);
    wr_mask  = cfg_wr && (cfg_addr == IDX_MASK);
    wr_stat  = cfg_wr && (cfg_addr == IDX_STAT);
    restart  = cfg_wr && (cfg_addr == IDX_RSTRT) && cfg_wdata[0];
    pkt_done = hs && hs_last && !restart;
    hit      = pkt_done && ((pcnt_q + 1'b1) >= pkts_per_irq);
    clr      = wr_stat ? cfg_wdata[1:0] : 2'b00;
    set      = {ovf_pulse && !restart, hit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en       <= 1'b0;
      base         <= '0;
      ring_len     <= ADDR_W'(RING_RST);
      pkt_len      <= LEN_W'(PLEN_RST);
      pkts_per_irq <= LEN_W'(PIRQ_RST);
      mask_q       <= '0;
      stat         <= '0;
      pcnt_q       <= '0;
      wr_ptr       <= '0;
      irq          <= 1'b0;
      cfg_rdata    <= '0;
    end else begin
      if (wr_ctrl) irq_en       <= cfg_wdata[0];
      if (wr_base) base         <= cfg_wdata;
      if (wr_ring) ring_len     <= cfg_wdata;
      if (wr_plen) pkt_len      <= cfg_wdata[LEN_W-1:0];
      if (wr_pirq) pkts_per_irq <= cfg_wdata[LEN_W-1:0];
      if (wr_mask) mask_q       <= cfg_wdata[1:0];

      if (restart)      wr_ptr <= base;
      else if (hs)      wr_ptr <= ring_step(hs_addr, base, ring_len);

      if (restart)       pcnt_q <= '0;
      else if (hit)      pcnt_q <= '0;
      else if (pkt_done) pcnt_q <= pcnt_q + 1'b1;

      stat <= (stat & ~clr) | set;
      irq  <= irq_en && |(stat & mask_q);

      case (cfg_addr)
        IDX_CTRL: cfg_rdata <= {31'd0, irq_en};
        IDX_BASE: cfg_rdata <= base;
        IDX_RING: cfg_rdata <= ring_len;
        IDX_PLEN: cfg_rdata <= {{(32-LEN_W){1'b0}}, pkt_len};
        IDX_PIRQ: cfg_rdata <= {{(32-LEN_W){1'b0}}, pkts_per_irq};
        IDX_WPTR: cfg_rdata <= wr_ptr;
        IDX_MASK: cfg_rdata <= {30'd0, mask_q};
        IDX_STAT: cfg_rdata <= {30'd0, stat};
        default:  cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ts_capture_dma.sv
module ts_capture_dma
  import ts_cap_pkg::*;
#(
  parameter int FIFO_DEPTH        = 8,
  parameter int unsigned RING_RST = 3760,
  parameter int unsigned PLEN_RST = 188,
  parameter int unsigned PIRQ_RST = 47
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  ts_data,
  input  logic        ts_valid,
  input  logic        ts_sop,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        irq
);
  localparam int EW = $bits(wr_entry_t);

  logic              restart, irq_en, push, ovf_pulse, q_empty, q_full, hs;
  logic [ADDR_W-1:0] base, ring_len, wr_ptr;
  logic [LEN_W-1:0]  pkt_len;
  logic [1:0]        stat;
  wr_entry_t         push_entry, head;

  assign mem_valid = !q_empty;
  assign mem_addr  = head.addr;
  assign mem_data  = head.data;
  assign hs        = mem_valid && mem_ready;

  ts_cap_regs #(
    .RING_RST(RING_RST), .PLEN_RST(PLEN_RST), .PIRQ_RST(PIRQ_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hs(hs),
    .hs_addr(head.addr), .hs_last(head.last), .ovf_pulse(ovf_pulse),
    .restart(restart), .irq_en(irq_en), .base(base), .ring_len(ring_len),
    .pkt_len(pkt_len), .stat(stat), .wr_ptr(wr_ptr), .irq(irq)
  );

  ts_cap_ingest u_ingest (
    .clk(clk), .rst(rst), .restart(restart), .ts_data(ts_data),
    .ts_valid(ts_valid), .ts_sop(ts_sop), .pkt_len(pkt_len), .base(base),
    .ring_len(ring_len), .q_full(q_full), .push(push),
    .push_entry(push_entry), .ovf_pulse(ovf_pulse)
  );

  ts_cap_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst(rst), .flush(restart), .push(push), .din(push_entry),
    .pop(hs), .dout(head), .empty(q_empty), .full(q_full)
  );
endmodule

// File: rtl/ts_capture_dma_chk.sv
module ts_capture_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data,
  input logic        irq,
  input logic        restart,
  input logic        irq_en,
  input logic [1:0]  stat,
  input logic [31:0] wr_ptr,
  input logic [31:0] base,
  input logic        cfg_wr,
  input logic [3:0]  cfg_addr,
  input logic [31:0] cfg_wdata
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready && !restart |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat[1] && !(cfg_wr && cfg_addr == 4'd7 && cfg_wdata[1]) |=> stat[1]);

  // R11
  restart_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (wr_ptr == $past(base)) && !mem_valid);
endmodule

bind ts_capture_dma ts_capture_dma_chk u_chk (.*);

// File: tb/ts_capture_dma_test.sv
module ts_capture_dma_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ts_data = '0;
  logic        ts_valid = 1'b0, ts_sop = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_valid, mem_ready = 1'b1, irq;
  logic [31:0] mem_addr, mem_data;

  always #2 clk = ~clk;

  ts_capture_dma #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ts_data(ts_data), .ts_valid(ts_valid), .ts_sop(ts_sop),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct { logic [31:0] a; logic [31:0] d; bit last; } ent_t;
  ent_t        q[$];
  bit          m_inpkt, m_en, m_irq;
  int          m_bcnt, m_lane, m_plen, m_pirq, m_pcnt;
  logic [7:0]  m_b[4];
  logic [31:0] m_push, m_pbase, m_wptr, m_base, m_ring;
  logic [1:0]  m_mask, m_stat;

  function automatic logic [31:0] nxt(input logic [31:0] a);
    if (a - m_base + 4 >= m_ring) return m_base;
    return a + 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_inpkt = 0; m_en = 0; m_irq = 0; m_bcnt = 0; m_lane = 0;
      m_plen = 188; m_pirq = 47; m_pcnt = 0; m_push = 0; m_pbase = 0; m_wptr = 0;
      m_base = 0; m_ring = 3760; m_mask = 0; m_stat = 0;
    end else begin
      bit full, hs, rs, setp, ovf, irq_n;
      ent_t e;
      logic [1:0] clr;
      full  = (q.size() == DEPTH);
      hs    = (q.size() > 0) && mem_ready;
      rs    = cfg_wr && cfg_addr == 4'd8 && cfg_wdata[0];
      irq_n = m_en && |(m_stat & m_mask);
      setp  = 0; ovf = 0;
      if (rs) begin
        q.delete(); m_inpkt = 0; m_lane = 0; m_push = m_base; m_pbase = m_base;
        m_wptr = m_base; m_pcnt = 0;
      end else begin
        if (hs) begin
          e = q.pop_front();
          m_wptr = nxt(e.a);
          if (e.last) begin
            if (m_pcnt + 1 >= m_pirq) begin m_pcnt = 0; setp = 1; end
            else m_pcnt++;
          end
        end
        if (ts_valid) begin
          if (!m_inpkt) begin
            if (ts_sop && ts_data == 8'h47) begin
              m_inpkt = 1; m_bcnt = 1; m_b[0] = ts_data; m_lane = 1;
            end
          end else begin
            m_b[m_lane] = ts_data; m_bcnt++;
            if (m_lane == 3) begin
              if (full) begin
                ovf = 1; m_inpkt = 0; m_lane = 0; m_push = m_pbase;
              end else begin
                e.a = m_push; e.d = {m_b[3], m_b[2], m_b[1], m_b[0]};
                e.last = (m_bcnt == m_plen);
                q.push_back(e);
                m_push = nxt(m_push);
                if (e.last) begin m_pbase = m_push; m_inpkt = 0; end
                m_lane = 0;
              end
            end else m_lane++;
          end
        end
      end
      clr    = (cfg_wr && cfg_addr == 4'd7) ? cfg_wdata[1:0] : 2'b00;
      m_stat = (m_stat & ~clr) | {ovf, setp};
      m_irq  = irq_n;
      if (cfg_wr) case (cfg_addr)
        4'd0: m_en   = cfg_wdata[0];
        4'd1: m_base = cfg_wdata;
        4'd2: m_ring = cfg_wdata;
        4'd3: m_plen = int'(cfg_wdata[15:0]);
        4'd4: m_pirq = int'(cfg_wdata[15:0]);
        4'd6: m_mask = cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  // per-clock comparison: R3 R4 R5 R8 R10 R11
  always @(negedge clk) begin
    if (!rst) begin
      check("R3/R5 mem_valid", {31'd0, mem_valid}, {31'd0, q.size() > 0});
      if (q.size() > 0 && mem_valid) begin
        check("R3 R4 mem_addr", mem_addr, q[0].a);
        check("R3 mem_data", mem_data, q[0].d);
      end
      check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); v = cfg_rdata;
  endtask

  task automatic send(input logic [7:0] first, input int len, input int sop_at, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ts_valid = 1;
      ts_data  = (i == 0) ? first : 8'(seed + i);
      ts_sop   = (i == 0) || (i == sop_at);
    end
    @(negedge clk); ts_valid = 0; ts_sop = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd3, v); check("R1 pkt length", v, 32'd188);
    rd(4'd4, v); check("R1 pkts per irq", v, 32'd47);
    rd(4'd5, v); check("R1 write pointer", v, 32'd0);
    rd(4'd0, v); check("R1 control", v, 32'd0);

    // small ring: 3 packets of 12 bytes, irq every 2 packets
    wr(4'd1, 32'h1000); wr(4'd2, 32'd36); wr(4'd3, 32'd12); wr(4'd4, 32'd2);
    wr(4'd6, 32'd1); wr(4'd0, 32'd1); wr(4'd8, 32'd1);

    send(8'h47, 12, -1, 8'h10); idle(4);
    rd(4'd5, v); check("R6 pointer after one packet", v, 32'h100C);

    // R2: bad sync, stray bytes, then a packet with a start mark inside it
    send(8'h46, 12, -1, 8'h20);
    send(8'h55, 5, -1, 8'h30);
    rd(4'd5, v); check("R2 rejected bytes not written", v, 32'h100C);
    send(8'h47, 12, 5, 8'h40); idle(4);
    rd(4'd5, v); check("R2 pointer after second packet", v, 32'h1018);
    rd(4'd7, v); check("R7 status after two packets", v, 32'd1);
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    wr(4'd7, 32'd1); idle(2);
    rd(4'd7, v); check("R9 status cleared", v, 32'd0);
    check("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R4 wrap
    send(8'h47, 12, -1, 8'h50); idle(4);
    rd(4'd5, v); check("R4 pointer wrapped to base", v, 32'h1000);

    // R5 stall then release
    mem_ready = 0;
    send(8'h47, 12, -1, 8'h60); idle(6);
    check("R5 word pending while stalled", {31'd0, mem_valid}, 32'd1);
    check("R5 held address", mem_addr, 32'h1000);
    mem_ready = 1; idle(6);
    rd(4'd5, v); check("R6 pointer after stall", v, 32'h100C);

    // R10 overflow: 12 words offered against an 8-word queue
    mem_ready = 0;
    for (int p = 0; p < 4; p++) send(8'h47, 12, -1, 8'h70 + p * 16);
    rd(4'd7, v); check("R10 overflow flag", v & 32'd2, 32'd2);
    mem_ready = 1; idle(12);
    send(8'h47, 12, -1, 8'hA0); idle(6);
    rd(4'd5, v); check("R10 pointer after rewind", v, m_wptr);
    rd(4'd7, v); check("R10 overflow sticky", v & 32'd2, 32'd2);
    wr(4'd7, 32'd3);

    // R11 restart in mid-packet under stall
    mem_ready = 0;
    send(8'h47, 6, -1, 8'hB0); idle(2);
    wr(4'd8, 32'd1);
    check("R11 queue emptied", {31'd0, mem_valid}, 32'd0);
    rd(4'd5, v); check("R11 pointer at base", v, 32'h1000);
    send(8'h47, 12, -1, 8'hC0);
    check("R11 first address at base", mem_addr, 32'h1000);
    check("R3 little-endian first word", mem_data, 32'hC3C2C147);
    mem_ready = 1; idle(6);

    // full-size packets, one per interrupt
    wr(4'd3, 32'd188); wr(4'd4, 32'd1); wr(4'd2, 32'd752); wr(4'd7, 32'd3);
    wr(4'd8, 32'd1);
    send(8'h47, 188, 100, 8'h00); idle(6);
    rd(4'd5, v); check("R6 pointer after 188-byte packet", v, 32'h1000 + 188);
    check("R7 irq after one full packet", {31'd0, irq}, 32'd1);

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule